// File: doc/BRIEF.md
# Indirect SRAM Access Channel

This block gives a host register port a window into a single-port on-chip SRAM, 64 bits at a time. The host programs an address register and a control register. It then reads or writes one data register. Each data write becomes one SRAM store and each data read becomes one SRAM load. The SRAM returns read data one cycle after the load is issued, so a data read stalls the host handshake by that one cycle. Register accesses and data writes are acknowledged in the cycle they are presented.

Three addressing modes share the data window:
- **Fixed mode** keeps hitting the word named by the address register.
- **Stream mode** uses the programmed address for the first access and then steps it by one 8-byte word per access, wrapping within the SRAM.
- **Ring mode** ignores the address register and treats a programmable region of the SRAM as a circular queue. Data writes push at the head and data reads pop at the tail.

Ring mode is guarded by an enable flag and a full flag that the host can poll. A rejected push or pop completes with an error response and leaves the SRAM and the queue untouched.

Top module: `sram_window_chan`

## Requirements
- R1: After reset the address register reads 0 and the queue configuration register reads 0. The control register reads 64'h6: fixed mode, queue disabled, full and empty both set, because a queue of length 0 has no room. host_ack stays low while host_req is low.
- R2: Select 0 is the address register. A write keeps wdata[63:32] as a 32-bit byte address. A read returns that address in bits [63:32] with bits [31:0] zero. The SRAM word used is (byte address >> 3) modulo the SRAM depth.
- R3: In fixed mode, every data access uses the same SRAM word until the address register is rewritten. A data write (select 1) drives one SRAM write cycle with the host data and is acknowledged in that same cycle without error.
- R4: A data read drives an SRAM read cycle and does not acknowledge in that cycle. The acknowledge comes exactly one cycle later, with host_rdata equal to the SRAM read data.
- R5: In stream mode, the first data access uses the programmed address. After each access the byte address becomes (address + 8) modulo (8 × SRAM depth), and the address register reads back the advanced value.
- R6: Control register (select 2) bits 59 and 58 pick the mode: both set gives ring mode, bit 59 alone gives stream mode, and any other value gives fixed mode. Bit 0 is the queue enable. Bit 1 reads the full flag and bit 2 reads the empty flag.
- R7: In ring mode, a push stores at word (base + head) modulo depth, then head becomes (head + 1) modulo length. Writes to the address register have no effect on ring accesses.
- R8: A push while the queue enable is clear is acknowledged with host_err set and causes no SRAM write.
- R9: The queue is full when advancing head would make it equal tail. A push while full is acknowledged with host_err set, causes no SRAM write, and leaves head unchanged.
- R10: In ring mode, a data read of a non-empty queue returns the word at (base + tail) modulo depth, then tail becomes (tail + 1) modulo length. A data read of an empty queue (head equals tail) is acknowledged with host_err set in the same cycle and issues no SRAM access.
- R11: Select 3 is the queue configuration register. A write sets base from wdata[AW-1:0] and length from wdata[16+AW:16], and clears head and tail. A read returns base in [AW-1:0], length in [16+AW:16], head in [32+AW-1:32] and tail in [48+AW-1:48].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 2 | Register select: 0 address, 1 data, 2 control, 3 queue config |
| host_wdata | input | 64 | Host write data |
| host_ack | output | 1 | Transfer complete |
| host_err | output | 1 | Error response, valid with host_ack |
| host_rdata | output | 64 | Host read data, valid with host_ack |
| sram_en | output | 1 | SRAM access strobe |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | AW | SRAM word address |
| sram_wdata | output | 64 | SRAM write data |
| sram_rdata | input | 64 | SRAM read data, one cycle after a read strobe |

## Verification
The assertions take for granted three things about the host:
- It holds host_req, host_we, host_sel and host_wdata stable until it sees host_ack.
- It drops host_req after the acknowledging edge.
- It never programs a queue region whose base plus length overruns the depth in a way the modulo arithmetic does not cover.

The SRAM is taken to return load data exactly one cycle after the strobe. The stimulus drives every transfer through a single task that follows this handshake. It uses a behavioural SRAM with that exact latency, and it uses only queue lengths of at least two.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_QCFG = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_FIXED  = 2'd0,
    MODE_STREAM = 2'd1,
    MODE_RING   = 2'd2
  } acc_mode_e;

  localparam int WORD_W     = 64;
  localparam int MODE_BIT_H = 59;
  localparam int MODE_BIT_L = 58;
  localparam int EN_BIT     = 0;
  localparam int FULL_BIT   = 1;
  localparam int EMPTY_BIT  = 2;

  function automatic acc_mode_e mode_of(input logic hi, input logic lo);
    if (hi && lo) return MODE_RING;
    if (hi)       return MODE_STREAM;
    return MODE_FIXED;
  endfunction

  // next byte address in stream mode, wrapping within 8 << aw bytes
  function automatic logic [31:0] stream_step(input logic [31:0] a,
                                              input int unsigned aw);
    return (a + 32'd8) & ((32'd8 << aw) - 32'd1);
  endfunction

  // next ring index for a queue of len entries
  function automatic int unsigned ring_step(input int unsigned idx,
                                            input int unsigned len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/swc_addr_gen.sv
module swc_addr_gen
  import swc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [31:0]   load_val,
  input  logic          step,
  output logic [31:0]   addr_q,
  output logic [AW-1:0] word
);
  localparam logic [31:0] SPAN = 32'd8 << AW;

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_val;
    else if (step) addr_q <= stream_step(addr_q, AW);
  end

  assign word = addr_q[AW+2:3];

  // R5
  stream_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr_q < SPAN));

endmodule

// File: rtl/swc_ring.sv
module swc_ring
  import swc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW:0]   cfg_len,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] base_q,
  output logic [AW:0]   len_q,
  output logic [AW-1:0] head,
  output logic [AW-1:0] tail,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] push_word,
  output logic [AW-1:0] pop_word
);
  logic [AW-1:0] head_nxt, tail_nxt;

  assign head_nxt  = AW'(ring_step(32'(head), 32'(len_q)));
  assign tail_nxt  = AW'(ring_step(32'(tail), 32'(len_q)));
  assign full      = (head_nxt == tail);
  assign empty     = (head == tail);
  assign push_word = base_q + head;
  assign pop_word  = base_q + tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
      head   <= '0;
      tail   <= '0;
    end else if (cfg_we) begin
      base_q <= cfg_base;
      len_q  <= cfg_len;
      head   <= '0;
      tail   <= '0;
    end else begin
      if (push) head <= head_nxt;
      if (pop)  tail <= tail_nxt;
    end
  end

  // R9
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && !cfg_we) |=> $stable(head));

  // R10
  no_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/sram_window_chan.sv
module sram_window_chan
  import swc_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [63:0]   host_wdata,
  output logic          host_ack,
  output logic          host_err,
  output logic [63:0]   host_rdata,
  output logic          sram_en,
  output logic          sram_we,
  output logic [AW-1:0] sram_addr,
  output logic [63:0]   sram_wdata,
  input  logic [63:0]   sram_rdata
);
  localparam int LEN_W = AW + 1;

  logic       waiting;
  logic [1:0] mode_raw;
  logic       q_en;
  acc_mode_e  mode;
  reg_sel_e   sel;

  logic req_live, reg_wr, data_acc, ring_mode;
  logic push_ok, push_err, pop_ok, pop_err, lin_acc, rd_issue, step;

  logic [31:0]      addr_q;
  logic [AW-1:0]    lin_word;
  logic [AW-1:0]    q_base, q_head, q_tail, push_word, pop_word;
  logic [LEN_W-1:0] q_len;
  logic             q_full, q_empty;
  logic [63:0]      reg_rdata;

  assign sel       = reg_sel_e'(host_sel);
  assign mode      = mode_of(mode_raw[1], mode_raw[0]);
  assign ring_mode = (mode == MODE_RING);
  assign req_live  = host_req && !waiting;
  assign reg_wr    = req_live && host_we;
  assign data_acc  = req_live && (sel == SEL_DATA);

  assign push_ok  = data_acc && host_we && ring_mode && q_en && !q_full;
  assign push_err = data_acc && host_we && ring_mode && (!q_en || q_full);
  assign pop_ok   = data_acc && !host_we && ring_mode && !q_empty;
  assign pop_err  = data_acc && !host_we && ring_mode && q_empty;
  assign lin_acc  = data_acc && !ring_mode;
  assign step     = lin_acc && (mode == MODE_STREAM);

  assign sram_en    = push_ok || pop_ok || lin_acc;
  assign sram_we    = sram_en && host_we;
  assign sram_wdata = host_wdata;
  assign rd_issue   = sram_en && !host_we;

  always_comb begin
    if (ring_mode) sram_addr = host_we ? push_word : pop_word;
    else           sram_addr = lin_word;
  end

  swc_addr_gen #(.AW(AW)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (reg_wr && (sel == SEL_ADDR)),
    .load_val (host_wdata[63:32]),
    .step     (step),
    .addr_q   (addr_q),
    .word     (lin_word)
  );

  swc_ring #(.AW(AW)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (reg_wr && (sel == SEL_QCFG)),
    .cfg_base  (host_wdata[AW-1:0]),
    .cfg_len   (host_wdata[16+AW:16]),
    .push      (push_ok),
    .pop       (pop_ok),
    .base_q    (q_base),
    .len_q     (q_len),
    .head      (q_head),
    .tail      (q_tail),
    .full      (q_full),
    .empty     (q_empty),
    .push_word (push_word),
    .pop_word  (pop_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waiting  <= 1'b0;
      mode_raw <= '0;
      q_en     <= 1'b0;
    end else begin
      waiting <= rd_issue;
      if (reg_wr && (sel == SEL_CTRL)) begin
        mode_raw <= {host_wdata[MODE_BIT_H], host_wdata[MODE_BIT_L]};
        q_en     <= host_wdata[EN_BIT];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_ADDR: reg_rdata = {addr_q, 32'h0};
      SEL_CTRL: begin
        reg_rdata[MODE_BIT_H] = mode_raw[1];
        reg_rdata[MODE_BIT_L] = mode_raw[0];
        reg_rdata[EN_BIT]     = q_en;
        reg_rdata[FULL_BIT]   = q_full;
        reg_rdata[EMPTY_BIT]  = q_empty;
      end
      SEL_QCFG: begin
        reg_rdata[AW-1:0]     = q_base;
        reg_rdata[16+AW:16]   = q_len;
        reg_rdata[32+AW-1:32] = q_head;
        reg_rdata[48+AW-1:48] = q_tail;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign host_ack   = waiting || (req_live && !rd_issue);
  assign host_err   = req_live && (push_err || pop_err);
  assign host_rdata = waiting ? sram_rdata : reg_rdata;

  // R4
  rd_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |=> (host_ack && !host_err));

  // R4
  no_early_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> !host_ack);

  // R8
  err_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> !sram_en);

  // R3
  fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lin_acc && (mode == MODE_FIXED)) |=> $stable(addr_q));

  // R7
  ring_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_en && ring_mode) |=> $stable(addr_q));

  // R1
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> host_req);

endmodule

// File: tb/sram_window_chan_bench.sv
module sram_window_chan_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_we = 1'b0;
  logic [1:0] host_sel = '0;
  logic [63:0] host_wdata = '0;
  logic host_ack, host_err;
  logic [63:0] host_rdata;
  logic sram_en, sram_we;
  logic [AW-1:0] sram_addr;
  logic [63:0] sram_wdata;
  logic [63:0] sram_rdata = '0;

  logic [63:0] mem [DEPTH];
  int wr_count = 0;
  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sram_window_chan #(.AW(AW)) u_sram_window_chan (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_ack(host_ack),
    .host_err(host_err), .host_rdata(host_rdata), .sram_en(sram_en),
    .sram_we(sram_we), .sram_addr(sram_addr), .sram_wdata(sram_wdata),
    .sram_rdata(sram_rdata));

  always_ff @(posedge clk) begin
    if (sram_en && sram_we) begin
      mem[sram_addr] <= sram_wdata;
      wr_count <= wr_count + 1;
    end
    if (sram_en && !sram_we) sram_rdata <= mem[sram_addr];
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [1:0] sel, input logic [63:0] wd,
                      output logic [63:0] rd, output logic err, output int lat);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_sel = sel; host_wdata = wd; lat = 0;
    #1;
    while (!host_ack && lat < 20) begin
      @(negedge clk); #1; lat++;
    end
    rd = host_rdata; err = host_err;
    @(posedge clk); #1;
    host_req = 1'b0;
  endtask

  logic [63:0] rv;
  logic        er;
  int          lt;

  function automatic logic [63:0] qcfg(input int base, input int len, input int head, input int tail);
    return (64'(tail) << 48) | (64'(head) << 32) | (64'(len) << 16) | 64'(base);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired got=%h exp=%h", 64'd1, 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle ack", 64'(host_ack), 64'd0);
    xfer(0, 2'd2, 0, rv, er, lt); chk("R1 ctrl reset", rv, 64'h6);
    xfer(0, 2'd0, 0, rv, er, lt); chk("R1 addr reset", rv, 64'h0);
    xfer(0, 2'd3, 0, rv, er, lt); chk("R1 qcfg reset", rv, 64'h0);

    // R2 address register packing
    xfer(1, 2'd0, {32'h0000_0028, 32'hFFFF_FFFF}, rv, er, lt);
    xfer(0, 2'd0, 0, rv, er, lt); chk("R2 addr readback", rv, {32'h28, 32'h0});

    // R3 fixed mode: word 5
    xfer(1, 2'd1, 64'hA5A5_0000_1111_0001, rv, er, lt);
    chk("R3 write lat", 64'(lt), 0);
    chk("R3 write err", 64'(er), 0);
    chk("R3 mem word5", mem[5], 64'hA5A5_0000_1111_0001);
    xfer(1, 2'd1, 64'h0BAD_F00D_2222_0002, rv, er, lt);
    chk("R3 same word", mem[5], 64'h0BAD_F00D_2222_0002);
    for (int k = 0; k < 2; k++) begin
      xfer(0, 2'd1, 0, rv, er, lt);
      chk("R4 read data", rv, 64'h0BAD_F00D_2222_0002);
      chk("R4 read latency", 64'(lt), 1);
    end
    xfer(0, 2'd0, 0, rv, er, lt); chk("R3 addr held", rv, {32'h28, 32'h0});

    // R6 bit 58 alone is still fixed mode
    xfer(1, 2'd2, 64'h1 << 58, rv, er, lt);
    xfer(1, 2'd1, 64'h77, rv, er, lt);
    xfer(0, 2'd0, 0, rv, er, lt); chk("R6 bit58 fixed", rv, {32'h28, 32'h0});

    // R5 stream sweep across the wrap
    xfer(1, 2'd2, 64'h1 << 59, rv, er, lt);
    xfer(1, 2'd0, {32'(60 * 8), 32'h0}, rv, er, lt);
    for (int i = 0; i < 8; i++) xfer(1, 2'd1, 64'h5000 + 64'(i), rv, er, lt);
    for (int i = 0; i < 8; i++) chk("R5 stream store", mem[(60 + i) % DEPTH], 64'h5000 + 64'(i));
    xfer(0, 2'd0, 0, rv, er, lt); chk("R5 addr advanced", rv, {32'((68 % DEPTH) * 8), 32'h0});
    xfer(1, 2'd0, {32'(60 * 8), 32'h0}, rv, er, lt);
    for (int i = 0; i < 8; i++) begin
      xfer(0, 2'd1, 0, rv, er, lt); chk("R5 stream load", rv, 64'h5000 + 64'(i));
    end
    xfer(1, 2'd0, {32'hFFFF_FFF8, 32'h0}, rv, er, lt);
    xfer(1, 2'd1, 64'hE0E0, rv, er, lt);
    chk("R5 high addr word", mem[DEPTH-1], 64'hE0E0);
    xfer(0, 2'd0, 0, rv, er, lt); chk("R5 modulo wrap", rv, 64'h0);

    // ring mode, disabled, base 10 len 4
    xfer(1, 2'd2, 64'h3 << 58, rv, er, lt);
    xfer(1, 2'd3, qcfg(10, 4, 0, 0), rv, er, lt);
    begin
      int wc;
      wc = wr_count;
      xfer(1, 2'd1, 64'hDEAD, rv, er, lt);
      chk("R8 disabled err", 64'(er), 1);
      chk("R8 no store", 64'(wr_count - wc), 0);
    end
    xfer(1, 2'd2, (64'h3 << 58) | 64'h1, rv, er, lt);
    xfer(1, 2'd0, {32'h0000_0100, 32'h0}, rv, er, lt);  // ignored in ring mode
    for (int i = 0; i < 3; i++) xfer(1, 2'd1, 64'hC000 + 64'(i), rv, er, lt);
    for (int i = 0; i < 3; i++) chk("R7 push store", mem[10 + i], 64'hC000 + 64'(i));
    xfer(0, 2'd2, 0, rv, er, lt); chk("R9 full flag", rv, (64'h3 << 58) | 64'h3);
    begin
      int wc;
      wc = wr_count;
      xfer(1, 2'd1, 64'hBEEF, rv, er, lt);
      chk("R9 full err", 64'(er), 1);
      chk("R9 no store", 64'(wr_count - wc), 0);
    end
    xfer(0, 2'd3, 0, rv, er, lt); chk("R9 head kept", rv, qcfg(10, 4, 3, 0));
    xfer(0, 2'd1, 0, rv, er, lt); chk("R10 pop data", rv, 64'hC000);
    xfer(0, 2'd3, 0, rv, er, lt); chk("R10 tail step", rv, qcfg(10, 4, 3, 1));
    xfer(1, 2'd3, qcfg(10, 4, 0, 0), rv, er, lt);
    xfer(0, 2'd3, 0, rv, er, lt); chk("R11 pointers clear", rv, qcfg(10, 4, 0, 0));
    xfer(0, 2'd1, 0, rv, er, lt); chk("R10 empty err", 64'(er), 1);
    chk("R10 empty no wait", 64'(lt), 0);

    // near-exhaustive ring sweep: base 62, length 5, crosses the SRAM end
    begin
      int hd, tl, ln, bs, wc, pc;
      logic [63:0] qd [5];
      bs = 62; ln = 5; hd = 0; tl = 0; pc = 0;
      xfer(1, 2'd3, qcfg(bs, ln, 0, 0), rv, er, lt);
      xfer(1, 2'd0, {32'h0000_0040, 32'h0}, rv, er, lt);
      for (int i = 0; i < 60; i++) begin
        if (((i * 5) % 7) < 4) begin
          logic [63:0] v;
          v = 64'h9000 + 64'(i);
          wc = wr_count;
          xfer(1, 2'd1, v, rv, er, lt);
          if ((hd + 1) % ln == tl) begin
            chk("R9 sweep full err", 64'(er), 1);
            chk("R9 sweep no store", 64'(wr_count - wc), 0);
          end else begin
            chk("R7 sweep push", mem[(bs + hd) % DEPTH], v);
            qd[hd] = v; hd = (hd + 1) % ln;
          end
        end else begin
          xfer(0, 2'd1, 0, rv, er, lt);
          if (hd == tl) chk("R10 sweep empty err", 64'(er), 1);
          else begin
            chk("R10 sweep pop", rv, qd[tl]);
            tl = (tl + 1) % ln; pc++;
          end
        end
        xfer(0, 2'd3, 0, rv, er, lt); chk("R11 sweep ptrs", rv, qcfg(bs, ln, hd, tl));
      end
      chk("R10 sweep popped", 64'(pc > 0), 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule